// File: doc/BRIEF.md
# Hardware Ticket Lock

This block is a fair mutual-exclusion lock for several requesters sharing one resource. It keeps two counters: a dispenser that hands out the next ticket number, and a service counter that names the ticket currently allowed in. When a port pulses its acquire line, it is given the dispenser's value as its own ticket in that cycle, and the dispenser moves forward. The port is granted the lock when the service counter equals its ticket. It gives the lock back by pulsing its release line, which moves the service counter forward by one.

Several ports may ask in the same cycle. They receive consecutive tickets, the lowest port index first. Because access follows ticket order, a waiting port is never overtaken by a later one. A release from a port that does not hold the lock changes nothing and raises a one-cycle error flag. An acquire from a port that already waits or holds is dropped.

Top module: `ticket_lock`

## Requirements
- R1: After reset both counters are zero, no grant is asserted and the error flag is low.
- R2: A single acquire on an idle lock, sampled at a rising edge, asserts that port's grant from that edge on.
- R3: At most one grant bit is high in any cycle.
- R4: A release by the holder drops its grant at the next edge, and the port holding the following ticket is granted at that same edge.
- R5: Acquires made in different cycles are granted in the order in which they were made.
- R6: Acquires made in the same cycle get consecutive tickets with the lower port index first, so they are granted in ascending port order.
- R7: A release from a port without the grant leaves every grant unchanged and sets the error flag high for exactly the one cycle after that edge.
- R8: An acquire from a port that is already waiting or holding is ignored: it takes no ticket, and the port is not granted a second time after it releases.
- R9: Both counters wrap modulo 2^TKT_W, and service stays correct across the wrap as long as no more than 2^TKT_W − 1 tickets are outstanding.
- R10: A holder's release and another port's acquire in the same cycle are both taken: the new port is queued behind every ticket already issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | N_PORTS | One-cycle acquire pulse per port |
| rel_req | input | N_PORTS | One-cycle release pulse per port |
| grant | output | N_PORTS | High for the port that holds the lock |
| rel_err | output | 1 | One-cycle pulse after a release from a non-holder |

## Verification
Ticket dispensing and lock release are handled by separate counters, and they can fall into the same cycle. The bench provokes this by pulsing the holder's release together with a fresh acquire from another port. This is done both with the queue empty and with a waiter already queued. The result is judged by the grant order that follows: the earlier waiter is served first, the new port next, and no port is granted twice. A valid and an invalid release in the same cycle are also combined. In that case the lock must advance and the error flag must pulse.

// File: rtl/tlock_pkg.sv
package tlock_pkg;

    typedef enum logic {
        SLOT_FREE     = 1'b0,
        SLOT_TICKETED = 1'b1
    } slot_e;

endpackage

// File: rtl/tlock_alloc.sv
module tlock_alloc #(
    parameter int N_PORTS = 4,
    parameter int TKT_W   = 3
) (
    input  logic [TKT_W-1:0]              base,
    input  logic [N_PORTS-1:0]            take,
    output logic [N_PORTS-1:0][TKT_W-1:0] tkt,
    output logic [TKT_W-1:0]              taken
);
    always_comb begin
        logic [TKT_W-1:0] ofs;
        ofs = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            tkt[i] = base + ofs;
            if (take[i]) ofs = ofs + TKT_W'(1);
        end
        taken = ofs;
    end
endmodule

// File: rtl/tlock_slot.sv
module tlock_slot
    import tlock_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [TKT_W-1:0] tkt_in,
    input  logic [TKT_W-1:0] now_srv,
    input  logic             rel,
    output logic             busy,
    output logic             holding
);
    typedef struct packed {
        slot_e            st;
        logic [TKT_W-1:0] tkt;
    } slot_t;

    slot_t s_d, s_q;

    assign busy    = (s_q.st == SLOT_TICKETED);
    assign holding = busy && (s_q.tkt == now_srv);

    always_comb begin
        s_d = s_q;
        if (!busy && take) begin
            s_d.st  = SLOT_TICKETED;
            s_d.tkt = tkt_in;
        end
        if (holding && rel) s_d.st = SLOT_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SLOT_FREE, tkt: '0};
        else        s_q <= s_d;
    end

    // R5: a queued port keeps its ticket until it releases as holder
    p_keep_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(holding && rel)) |=> (busy && $stable(s_q.tkt)));

    // R8: an acquire while busy never rewrites the ticket
    p_no_retake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && take) |=> $stable(s_q.tkt));
endmodule

// File: rtl/ticket_lock.sv
module ticket_lock #(
    parameter int N_PORTS = 4,
    parameter int TKT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] acq_req,
    input  logic [N_PORTS-1:0] rel_req,
    output logic [N_PORTS-1:0] grant,
    output logic               rel_err
);
    localparam logic [TKT_W-1:0] ONE = TKT_W'(1);

    typedef struct packed {
        logic [TKT_W-1:0] next_tkt;
        logic [TKT_W-1:0] now_srv;
        logic             err;
    } ctr_t;

    ctr_t c_d, c_q;

    logic [N_PORTS-1:0]            busy;
    logic [N_PORTS-1:0]            take;
    logic [N_PORTS-1:0][TKT_W-1:0] tkt;
    logic [TKT_W-1:0]              taken;
    logic [N_PORTS-1:0]            good_rel;
    logic [N_PORTS-1:0]            bad_rel;

    assign take     = acq_req & ~busy;
    assign good_rel = rel_req & grant;
    assign bad_rel  = rel_req & ~grant;

    tlock_alloc #(.N_PORTS(N_PORTS), .TKT_W(TKT_W)) u_alloc (
        .base  (c_q.next_tkt),
        .take  (take),
        .tkt   (tkt),
        .taken (taken)
    );

    for (genvar g = 0; g < N_PORTS; g++) begin : g_slot
        tlock_slot #(.TKT_W(TKT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take[g]),
            .tkt_in  (tkt[g]),
            .now_srv (c_q.now_srv),
            .rel     (rel_req[g]),
            .busy    (busy[g]),
            .holding (grant[g])
        );
    end

    always_comb begin
        c_d          = c_q;
        c_d.next_tkt = c_q.next_tkt + taken;
        if (|good_rel) c_d.now_srv = c_q.now_srv + ONE;
        c_d.err      = |bad_rel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{next_tkt: '0, now_srv: '0, err: 1'b0};
        else        c_q <= c_d;
    end

    assign rel_err = c_q.err;

    // R3: mutual exclusion
    p_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: a holder release advances service by exactly one
    p_serve_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|good_rel) |=> (c_q.now_srv == $past(c_q.now_srv) + ONE));

    // R7: a stray release flags an error in the following cycle
    p_bad_rel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|bad_rel) |=> rel_err);

    // R7: no stray release means no error pulse
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|bad_rel) |=> !rel_err);

    // R9: outstanding tickets never exceed the port count
    p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (TKT_W'(c_q.next_tkt - c_q.now_srv) <= TKT_W'(N_PORTS)));
endmodule

// File: tb/ticket_lock_test.sv
module ticket_lock_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] acq_req = '0;
    logic [N-1:0] rel_req = '0;
    logic [N-1:0] grant;
    logic         rel_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ticket_lock #(.N_PORTS(N), .TKT_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
        .grant(grant), .rel_err(rel_err)
    );

    task automatic chk(input string req, input logic [N-1:0] exp_g, input logic exp_e);
        checks++;
        if (grant !== exp_g || rel_err !== exp_e) begin
            fails++;
            $display("FAIL %s: grant=%b err=%b expected grant=%b err=%b",
                     req, grant, rel_err, exp_g, exp_e);
        end
    endtask

    // drive one cycle of pulses; return just after the sampling edge
    task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] r);
        acq_req = a;
        rel_req = r;
        @(posedge clk);
        #1;
        acq_req = '0;
        rel_req = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 4'b0000, 1'b0);
        rst_n = 1'b1;
        cyc(4'b0000, 4'b0000);
        chk("R1 idle after reset", 4'b0000, 1'b0);
    endtask

    task automatic t_single;
        cyc(4'b0100, 4'b0000);
        chk("R2 single acquire", 4'b0100, 1'b0);
        cyc(4'b0000, 4'b0100);
        chk("R4 release to idle", 4'b0000, 1'b0);
    endtask

    task automatic t_fifo;
        cyc(4'b1000, 4'b0000);
        cyc(4'b0001, 4'b0000);
        cyc(4'b0010, 4'b0000);
        chk("R5 first arrival holds", 4'b1000, 1'b0);
        cyc(4'b0000, 4'b1000);
        chk("R4 R5 second arrival", 4'b0001, 1'b0);
        cyc(4'b0000, 4'b0001);
        chk("R5 third arrival", 4'b0010, 1'b0);
        cyc(4'b0000, 4'b0010);
        chk("R5 drained", 4'b0000, 1'b0);
    endtask

    task automatic t_same_cycle;
        cyc(4'b1111, 4'b0000);
        for (int i = 0; i < N; i++) begin
            chk("R6 ascending order", 4'(1 << i), 1'b0);
            cyc(4'b0000, 4'(1 << i));
        end
        chk("R6 drained", 4'b0000, 1'b0);
    endtask

    task automatic t_bad_release;
        cyc(4'b0001, 4'b0000);
        cyc(4'b0010, 4'b0000);
        cyc(4'b0000, 4'b0110);
        chk("R7 stray release flagged", 4'b0001, 1'b1);
        cyc(4'b0000, 4'b0000);
        chk("R7 one-cycle pulse", 4'b0001, 1'b0);
        cyc(4'b0000, 4'b1001);
        chk("R7 valid plus stray release", 4'b0010, 1'b1);
        cyc(4'b0000, 4'b0010);
        chk("R7 drained", 4'b0000, 1'b0);
    endtask

    task automatic t_reacquire;
        cyc(4'b0001, 4'b0000);
        cyc(4'b0011, 4'b0000);
        chk("R8 holder keeps lock", 4'b0001, 1'b0);
        cyc(4'b0000, 4'b0001);
        chk("R8 waiter next", 4'b0010, 1'b0);
        cyc(4'b0000, 4'b0010);
        chk("R8 no extra ticket", 4'b0000, 1'b0);
    endtask

    task automatic t_overlap;
        cyc(4'b0001, 4'b0000);
        cyc(4'b0000, 4'b0000);
        cyc(4'b0100, 4'b0001);
        chk("R10 release with acquire, empty queue", 4'b0100, 1'b0);
        cyc(4'b0010, 4'b0000);
        cyc(4'b1000, 4'b0100);
        chk("R10 earlier waiter first", 4'b0010, 1'b0);
        cyc(4'b0000, 4'b0010);
        chk("R10 new port after", 4'b1000, 1'b0);
        cyc(4'b0000, 4'b1000);
        chk("R10 drained", 4'b0000, 1'b0);
    endtask

    task automatic t_wrap;
        for (int k = 0; k < 20; k++) begin
            cyc(4'(1 << (k % N)), 4'b0000);
            chk("R9 wrap grant", 4'(1 << (k % N)), 1'b0);
            cyc(4'b0000, 4'(1 << (k % N)));
        end
        cyc(4'b1111, 4'b0000);
        for (int i = 0; i < N; i++) begin
            chk("R9 R3 full queue after wrap", 4'(1 << i), 1'b0);
            cyc(4'b0000, 4'(1 << i));
        end
        chk("R9 drained", 4'b0000, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single();
                t_fifo();
                t_same_cycle();
                t_bad_release();
                t_reacquire();
                t_overlap();
                t_wrap();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule